// File: doc/BRIEF.md
# Bad-Block Mark Swap Unit

This unit exchanges one byte-wide field of a page data buffer with byte 0 of the page's auxiliary (metadata) buffer. The field starts at a byte offset plus a bit offset 0..7. Because the bit offset can be nonzero, the field may cover the upper bits of one data byte and the lower bits of the byte after it. The controller that lays out pages on the flash device calls the unit before it programs a page, so the physical bad-block mark position holds the metadata byte. It calls the unit again after it reads a page, to move that byte back. Running the exchange twice restores both buffers, so one operation serves both paths.

A start pulse latches the byte offset and bit offset. The unit reads the two data bytes and the auxiliary byte through synchronous single-port memory interfaces, where read data is valid in the cycle after the read strobe. It then merges the bits and writes all three bytes back. A one-cycle done pulse follows the last write.

Top module: `bbm_swap_unit`

## Requirements
- R1: After reset, busy and done are low and no read or write strobe is active on either memory port.
- R2: The auxiliary byte 0 receives bits s..s+7 of the 16-bit value {data[b+1], data[b]}, where b is the byte offset and s is the bit offset.
- R3: Bits 0..s-1 of data[b] are unchanged, and bits s..7 of data[b] receive the old auxiliary bits 0..7-s.
- R4: Bits s..7 of data[b+1] are unchanged, and bits 0..s-1 of data[b+1] receive the old auxiliary bits 8-s..7.
- R5: With s equal to 0 the unit does not write data[b+1], and the operation is a plain exchange of data[b] with the auxiliary byte.
- R6: In the cycles that follow the start, the memory strobes occur in this order, one per cycle: a read of data[b], a read of data[b+1], a read of the auxiliary byte, a write of data[b], a write of data[b+1] (skipped when s is 0), and a write of the auxiliary byte. At most one strobe is active in any cycle.
- R7: busy is high for exactly six cycles. done is a single-cycle pulse in the cycle after the auxiliary write, and busy is low in that cycle.
- R8: A start that arrives while busy is high is ignored. It neither restarts nor queues an operation.
- R9: Two operations with the same offsets restore the original contents of both buffers.
- R10: No data address other than b and b+1 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange when idle |
| mark_byte | input | ADDR_W | Byte offset b of the mark field |
| mark_bit | input | $clog2(BYTE_W) | Bit offset s of the mark field |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| dmem_addr | output | ADDR_W | Data buffer address |
| dmem_rd_en | output | 1 | Data buffer read strobe |
| dmem_rdata | input | BYTE_W | Data buffer read data, valid the cycle after the strobe |
| dmem_wr_en | output | 1 | Data buffer write strobe |
| dmem_wdata | output | BYTE_W | Data buffer write data |
| aux_rd_en | output | 1 | Auxiliary byte 0 read strobe |
| aux_rdata | input | BYTE_W | Auxiliary read data, valid the cycle after the strobe |
| aux_wr_en | output | 1 | Auxiliary byte 0 write strobe |
| aux_wdata | output | BYTE_W | Auxiliary write data |

## Verification
The bench builds the unit with ADDR_W = 4 and BYTE_W = 8. With these values the whole 16-byte data buffer is compared after every exchange, which shows that only bytes b and b+1 change. The small buffer also lets the bench place the field at the last valid pair of bytes (b = 14). A bit-by-bit reference model covers every bit offset from 0 to 7, so the straddling merge and the whole-byte case at s = 0 are both checked against the same independent rule.

// File: rtl/bbm_swap_unit.sv
module bbm_swap_unit #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          mark_byte,
  input  logic [$clog2(BYTE_W)-1:0]  mark_bit,
  output logic                       busy,
  output logic                       done,
  output logic [ADDR_W-1:0]          dmem_addr,
  output logic                       dmem_rd_en,
  input  logic [BYTE_W-1:0]          dmem_rdata,
  output logic                       dmem_wr_en,
  output logic [BYTE_W-1:0]          dmem_wdata,
  output logic                       aux_rd_en,
  input  logic [BYTE_W-1:0]          aux_rdata,
  output logic                       aux_wr_en,
  output logic [BYTE_W-1:0]          aux_wdata
);
  localparam int OFS_W = $clog2(BYTE_W);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAIR_W-1:0] LOW_ONES = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_RD_AUX, ST_WR_LO, ST_WR_HI, ST_WR_AUX
  } state_t;

  state_t              state;
  logic [ADDR_W-1:0]   base_q;
  logic [OFS_W-1:0]    shift_q;
  logic [BYTE_W-1:0]   lo_q, hi_q, aux_q;
  logic                done_q;

  logic [BYTE_W-1:0]   old_aux;
  logic [PAIR_W-1:0]   pair, pair_sh, merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      shift_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      aux_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          base_q  <= mark_byte;
          shift_q <= mark_bit;
          state   <= ST_RD_LO;
        end
        ST_RD_LO:  state <= ST_RD_HI;
        ST_RD_HI: begin
          lo_q  <= dmem_rdata;
          state <= ST_RD_AUX;
        end
        ST_RD_AUX: begin
          hi_q  <= dmem_rdata;
          state <= ST_WR_LO;
        end
        ST_WR_LO: begin
          aux_q <= aux_rdata;
          state <= ST_WR_HI;
        end
        ST_WR_HI:  state <= ST_WR_AUX;
        ST_WR_AUX: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign old_aux = (state == ST_WR_LO) ? aux_rdata : aux_q;
  assign pair    = {hi_q, lo_q};
  assign pair_sh = pair >> shift_q;
  assign merged  = (pair & ~(LOW_ONES << shift_q))
                 | ({{BYTE_W{1'b0}}, old_aux} << shift_q);

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign dmem_rd_en = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign dmem_wr_en = (state == ST_WR_LO) || ((state == ST_WR_HI) && (shift_q != '0));
  assign dmem_addr  = ((state == ST_RD_HI) || (state == ST_WR_HI)) ? base_q + ADDR_ONE : base_q;
  assign dmem_wdata = (state == ST_WR_HI) ? merged[PAIR_W-1:BYTE_W] : merged[BYTE_W-1:0];
  assign aux_rd_en  = (state == ST_RD_AUX);
  assign aux_wr_en  = (state == ST_WR_AUX);
  assign aux_wdata  = pair_sh[BYTE_W-1:0];
endmodule

// File: rtl/bbm_swap_unit_chk.sv
module bbm_swap_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic dmem_rd_en,
  input logic dmem_wr_en,
  input logic aux_rd_en,
  input logic aux_wr_en
);
  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dmem_rd_en, dmem_wr_en, aux_rd_en, aux_wr_en}));

  assert_first_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dmem_rd_en);

  assert_write_after_aux_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rd_en |=> dmem_wr_en);

  assert_done_after_aux_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr_en |=> (done && !busy));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dmem_rd_en || dmem_wr_en || aux_rd_en || aux_wr_en));
endmodule

bind bbm_swap_unit bbm_swap_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en),
  .aux_rd_en(aux_rd_en), .aux_wr_en(aux_wr_en)
);

// File: tb/bbm_swap_unit_tb_top.sv
`timescale 1ns/1ps
module bbm_swap_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mark_byte = '0;
  logic [2:0] mark_bit = '0;
  logic busy, done;
  logic [3:0] dmem_addr;
  logic dmem_rd_en, dmem_wr_en, aux_rd_en, aux_wr_en;
  logic [7:0] dmem_rdata = '0, aux_rdata = '0, dmem_wdata, aux_wdata;

  logic [7:0] mem [16];
  logic [7:0] aux_mem;
  logic       ld_we = 1'b0, ld_aux_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  logic [7:0] exp_mem [16];
  logic [7:0] exp_aux;
  logic [7:0] save_mem [16];
  logic [7:0] save_aux;

  logic [3:0] op_log [8];
  logic [3:0] addr_log [8];
  int last_n;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bbm_swap_unit #(.ADDR_W(4), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mark_byte(mark_byte), .mark_bit(mark_bit),
    .busy(busy), .done(done), .dmem_addr(dmem_addr), .dmem_rd_en(dmem_rd_en),
    .dmem_rdata(dmem_rdata), .dmem_wr_en(dmem_wr_en), .dmem_wdata(dmem_wdata),
    .aux_rd_en(aux_rd_en), .aux_rdata(aux_rdata), .aux_wr_en(aux_wr_en), .aux_wdata(aux_wdata)
  );

  always @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
    if (ld_aux_we) aux_mem <= ld_data;
    if (dmem_wr_en) mem[dmem_addr] <= dmem_wdata;
    if (dmem_rd_en) dmem_rdata <= mem[dmem_addr];
    if (aux_wr_en) aux_mem <= aux_wdata;
    if (aux_rd_en) aux_rdata <= aux_mem;
  end

  // {b[3:0], s[2:0], data[b], data[b+1], aux}
  localparam logic [30:0] VEC [8] = '{
    {4'd0,  3'd0, 8'hA5, 8'h3C, 8'h00},
    {4'd3,  3'd1, 8'h81, 8'h7E, 8'hFF},
    {4'd5,  3'd3, 8'hF0, 8'h0F, 8'h5A},
    {4'd7,  3'd4, 8'h12, 8'h34, 8'hC3},
    {4'd2,  3'd7, 8'h80, 8'h01, 8'h00},
    {4'd14, 3'd5, 8'hFF, 8'hFF, 8'h00},
    {4'd9,  3'd2, 8'h00, 8'h00, 8'hFF},
    {4'd11, 3'd6, 8'h6B, 8'hD2, 8'h99}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [3:0] a, input logic [7:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic put_aux(input logic [7:0] d);
    ld_aux_we = 1'b1; ld_data = d;
    @(negedge clk);
    ld_aux_we = 1'b0;
  endtask

  task automatic fill_background();
    for (int a = 0; a < 16; a++) begin
      put(4'(a), 8'(a * 29 + 7));
      exp_mem[4'(a)] = 8'(a * 29 + 7);
    end
  endtask

  task automatic model_swap(input logic [3:0] b, input logic [2:0] s);
    for (int i = 0; i < 8; i++) begin
      int pos;
      logic [3:0] idx;
      logic [2:0] bt;
      logic t;
      pos = 8 * int'(b) + int'(s) + i;
      idx = 4'(pos >> 3);
      bt  = 3'(pos & 7);
      t = exp_mem[idx][bt];
      exp_mem[idx][bt] = exp_aux[3'(i)];
      exp_aux[3'(i)] = t;
    end
  endtask

  task automatic do_swap(input logic [3:0] b, input logic [2:0] s,
                         input int glitch_at, input logic [3:0] gb, input logic [2:0] gs);
    int n;
    @(negedge clk);
    start = 1'b1; mark_byte = b; mark_bit = s;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20) begin
      if (n < 8) begin
        op_log[3'(n)] = {dmem_rd_en, dmem_wr_en, aux_rd_en, aux_wr_en};
        addr_log[3'(n)] = dmem_addr;
      end
      if (n == glitch_at) begin
        start = 1'b1; mark_byte = gb; mark_bit = gs;
      end else begin
        start = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    last_n = n;
    if (n >= 20) check(1'b0, "R7", "operation timeout", 32'(n), 32'd6);
  endtask

  task automatic check_buffers(input string req);
    int bad;
    bad = -1;
    for (int a = 0; a < 16; a++)
      if (bad < 0 && mem[4'(a)] !== exp_mem[4'(a)]) bad = a;
    if (bad < 0) check(1'b1, req, "data buffer", 0, 0);
    else check(1'b0, req, $sformatf("data[%0d]", bad), 32'(mem[4'(bad)]), 32'(exp_mem[4'(bad)]));
    check(aux_mem === exp_aux, "R2", "aux byte 0", 32'(aux_mem), 32'(exp_aux));
  endtask

  task automatic load_case(input logic [3:0] b, input logic [7:0] lo,
                           input logic [7:0] hi, input logic [7:0] ax);
    fill_background();
    put(b, lo); exp_mem[b] = lo;
    put(b + 4'd1, hi); exp_mem[b + 4'd1] = hi;
    put_aux(ax); exp_aux = ax;
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", 32'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({dmem_rd_en, dmem_wr_en, aux_rd_en, aux_wr_en, busy, done} === 6'b0, "R1",
          "strobes after reset", 32'({dmem_rd_en, dmem_wr_en, aux_rd_en, aux_wr_en, busy, done}), 0);

    // vector table: R2, R3, R4, R10
    for (int k = 0; k < 8; k++) begin
      logic [30:0] v;
      v = VEC[3'(k)];
      load_case(v[30:27], v[23:16], v[15:8], v[7:0]);
      model_swap(v[30:27], v[26:24]);
      do_swap(v[30:27], v[26:24], -1, 4'd0, 3'd0);
      check_buffers("R3 R4 R10");
    end

    // R6 / R7 strobe order and timing, b=5 s=3
    load_case(4'd5, 8'hC6, 8'h39, 8'hE1);
    model_swap(4'd5, 3'd3);
    do_swap(4'd5, 3'd3, -1, 4'd0, 3'd0);
    check(last_n == 6, "R7", "busy cycles", 32'(last_n), 32'd6);
    check(done === 1'b1 && busy === 1'b0, "R7", "done with busy low", 32'({done, busy}), 32'b10);
    check(op_log[0] == 4'b1000 && addr_log[0] == 4'd5, "R6", "cycle1 read b", 32'({op_log[0], addr_log[0]}), 32'h85);
    check(op_log[1] == 4'b1000 && addr_log[1] == 4'd6, "R6", "cycle2 read b+1", 32'({op_log[1], addr_log[1]}), 32'h86);
    check(op_log[2] == 4'b0010, "R6", "cycle3 aux read", 32'(op_log[2]), 32'h2);
    check(op_log[3] == 4'b0100 && addr_log[3] == 4'd5, "R6", "cycle4 write b", 32'({op_log[3], addr_log[3]}), 32'h45);
    check(op_log[4] == 4'b0100 && addr_log[4] == 4'd6, "R6", "cycle5 write b+1", 32'({op_log[4], addr_log[4]}), 32'h46);
    check(op_log[5] == 4'b0001, "R6", "cycle6 aux write", 32'(op_log[5]), 32'h1);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single pulse", 32'(done), 0);
    check_buffers("R3 R4");

    // R5 whole-byte exchange, no write to b+1
    load_case(4'd4, 8'h5E, 8'hB7, 8'h21);
    model_swap(4'd4, 3'd0);
    do_swap(4'd4, 3'd0, -1, 4'd0, 3'd0);
    check(op_log[4] == 4'b0000, "R5", "no write in cycle5", 32'(op_log[4]), 0);
    check(mem[4'd4] === 8'h21 && mem[4'd5] === 8'hB7 && aux_mem === 8'h5E, "R5", "whole byte exchange",
          32'({mem[4'd4], mem[4'd5], aux_mem}), 32'h21B75E);

    // R8 start while busy ignored
    load_case(4'd8, 8'h3A, 8'hC5, 8'h7F);
    model_swap(4'd8, 3'd5);
    do_swap(4'd8, 3'd5, 2, 4'd1, 3'd2);
    check(last_n == 6, "R8", "busy cycles unchanged", 32'(last_n), 32'd6);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R8", "no queued operation", 32'(busy), 0);
    check_buffers("R8");

    // R9 involution
    load_case(4'd12, 8'h96, 8'h4D, 8'hE8);
    for (int a = 0; a < 16; a++) save_mem[4'(a)] = exp_mem[4'(a)];
    save_aux = exp_aux;
    do_swap(4'd12, 3'd6, -1, 4'd0, 3'd0);
    do_swap(4'd12, 3'd6, -1, 4'd0, 3'd0);
    for (int a = 0; a < 16; a++) exp_mem[4'(a)] = save_mem[4'(a)];
    exp_aux = save_aux;
    check_buffers("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule